// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Pin Peripheral Takeover

This block is an eight-pin bidirectional I/O port for a register-mapped control bus. Each pin has an output value latch and a direction latch. Both are written from a shared write-data bus through two separate single-cycle strobes. A direction bit of one makes the pin an input, so its pad driver is released. A direction bit of zero makes the pin drive its latched value.

Each pin can also be handed to an on-chip peripheral through a per-pin select. While the select is high, the peripheral supplies both the value and the drive enable of that pin. The peripheral's drive enable is ignored while the select is low. Pad levels pass through a synchroniser before they reach the register read path and the peripheral input path. Two pins also carry a pad-level mode flag, which chooses an alternate input threshold in the pad.

The bus interface is plain strobes and levels with no handshake. Writes complete in the cycle of their strobe. The read selector is registered, and read data follows the registered selector combinationally.

Top module: `gpio_port_ovr`

## Requirements
- R1: After reset, every direction bit is 1, every output latch bit is 0, and no pin is driven while its peripheral select is low.
- R2: With its peripheral select low, a pin's `pad_oe` is 1 exactly when its direction bit is 0, and its `pad_out` equals its output latch bit.
- R3: With its peripheral select high, a pin's `pad_out` equals that pin's `per_dout` bit, whatever the output latch holds.
- R4: With its peripheral select high, a pin's `pad_oe` equals that pin's `per_oe` bit, whatever the direction latch holds. This can force the pin to output or force it to input.
- R5: With the registered selector at 1, `rdata` returns the direction latch contents, not the direction actually in effect on the pads.
- R6: With the registered selector at 0, `rdata` returns `pad_in` delayed by two clock edges. `per_din` carries that same delayed value at all times.
- R7: `pad_lvl` bits 3 and 4 equal `lvl_mode`, and all other `pad_lvl` bits are 0. The flag has no effect on any other output.
- R8: The output latch can be written while its pin is an input. The stored value drives the pin as soon as the direction bit is cleared.
- R9: `data_we` loads only the output latch and `dir_we` loads only the direction latch. Each latch holds its value on any edge where its own strobe is low.
- R10: `rd_sel` is captured on each clock edge: 0 selects the pin levels and 1 selects the direction latch. `rdata` follows the captured value, not the live input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wdata | input | 8 | Write data for both latches |
| data_we | input | 1 | Output latch write strobe |
| dir_we | input | 1 | Direction latch write strobe |
| rd_sel | input | 1 | Read selector (0 pins, 1 direction) |
| rdata | output | 8 | Read data |
| per_sel | input | 8 | Per-pin peripheral takeover |
| per_dout | input | 8 | Peripheral output values |
| per_oe | input | 8 | Peripheral drive enables (1 = drive) |
| per_din | output | 8 | Synchronised pin levels to peripherals |
| lvl_mode | input | 1 | Alternate input threshold request |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad drive enables (1 = drive) |
| pad_in | input | 8 | Raw pad levels |
| pad_lvl | output | 8 | Pad threshold mode flags |

## Verification
The assertions take for granted that reset is held for at least one clock edge before any check is armed. The synchroniser checks wait one further edge so that flop contents from before reset are never compared. They also take for granted that every input is stable around the rising edge. The stimulus meets both conditions: it changes every input only on the falling edge, and it holds reset across several edges. It draws the write strobes, selects, enables and pad levels at random from a fixed seed, so takeover and plain port control mix on pins in the same cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic {
    RD_PINS = 1'b0,
    RD_DIR  = 1'b1
  } rd_sel_e;

  localparam int unsigned PORT_W = 8;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] wdata,
  input  logic         data_we,
  input  logic         dir_we,
  input  logic         rd_sel,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q,
  output rd_sel_e      rd_sel_q
);
  localparam logic [W-1:0] DIR_RST  = '1;
  localparam logic [W-1:0] DATA_RST = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= DATA_RST;
    end else if (data_we) begin
      data_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= DIR_RST;
    end else if (dir_we) begin
      dir_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_sel_q <= RD_PINS;
    else     rd_sel_q <= rd_sel_e'(rd_sel);
  end

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !data_we |=> $stable(data_q)); // R9
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !dir_we |=> $stable(dir_q)); // R9
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] synced
);
  logic [W-1:0] stg [STAGES];
  logic         armed;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= raw;
  end

  generate
    for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[k] <= '0;
        else     stg[k] <= stg[k-1];
      end

      AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (rst)
        armed |-> stg[k] == $past(stg[k-1])); // R6
    end
  endgenerate

  always_ff @(posedge clk) armed <= !rst;

  assign synced = stg[STAGES-1];

  AST_SYNC_ENTRY: assert property (@(posedge clk) disable iff (rst)
    armed |-> stg[0] == $past(raw)); // R6
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int unsigned  W        = 8,
  parameter logic [W-1:0] LVL_MASK = 8'b0001_1000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] data_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] per_sel,
  input  logic [W-1:0] per_dout,
  input  logic [W-1:0] per_oe,
  input  logic         lvl_mode,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_lvl
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      always_comb begin
        if (per_sel[i]) begin
          pad_out[i] = per_dout[i];
          pad_oe[i]  = per_oe[i];
        end else begin
          pad_out[i] = data_q[i];
          pad_oe[i]  = ~dir_q[i];
        end
      end

      if (LVL_MASK[i]) begin : g_lvl
        assign pad_lvl[i] = lvl_mode;
      end else begin : g_nolvl
        assign pad_lvl[i] = 1'b0;
      end
    end
  endgenerate

  AST_LVL_CONFINED: assert property (@(posedge clk) disable iff (rst)
    (pad_lvl & ~LVL_MASK) == '0); // R7
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
  import gpio_pkg::*;
#(
  parameter int unsigned  W           = PORT_W,
  parameter int unsigned  SYNC_STAGES = 2,
  parameter logic [W-1:0] LVL_MASK    = 8'b0001_1000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] wdata,
  input  logic         data_we,
  input  logic         dir_we,
  input  logic         rd_sel,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] per_sel,
  input  logic [W-1:0] per_dout,
  input  logic [W-1:0] per_oe,
  output logic [W-1:0] per_din,
  input  logic         lvl_mode,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_lvl
);
  logic [W-1:0] data_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] pins_sync;
  rd_sel_e      rd_sel_q;

  gpio_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wdata    (wdata),
    .data_we  (data_we),
    .dir_we   (dir_we),
    .rd_sel   (rd_sel),
    .data_q   (data_q),
    .dir_q    (dir_q),
    .rd_sel_q (rd_sel_q)
  );

  gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw    (pad_in),
    .synced (pins_sync)
  );

  gpio_pin_mux #(.W(W), .LVL_MASK(LVL_MASK)) u_mux (
    .clk      (clk),
    .rst      (rst),
    .data_q   (data_q),
    .dir_q    (dir_q),
    .per_sel  (per_sel),
    .per_dout (per_dout),
    .per_oe   (per_oe),
    .lvl_mode (lvl_mode),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pad_lvl  (pad_lvl)
  );

  assign per_din = pins_sync;

  always_comb begin
    unique case (rd_sel_q)
      RD_DIR:  rdata = dir_q;
      default: rdata = pins_sync;
    endcase
  end

  AST_NO_DRIVE_INPUT: assert property (@(posedge clk) disable iff (rst)
    (~per_sel & dir_q & pad_oe) == '0); // R2
  AST_PERIPH_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (per_sel & per_oe & ~pad_oe) == '0); // R4
  AST_PERIPH_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (per_sel & ~per_oe & pad_oe) == '0); // R4
  AST_PERIPH_VALUE: assert property (@(posedge clk) disable iff (rst)
    (per_sel & (pad_out ^ per_dout)) == '0); // R3
endmodule

// File: tb/gpio_port_ovr_test.sv
`timescale 1ns/1ps
module gpio_port_ovr_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] wdata, per_sel, per_dout, per_oe, pad_in;
  logic       data_we, dir_we, rd_sel, lvl_mode;
  logic [7:0] rdata, per_din, pad_out, pad_oe, pad_lvl;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] m_data, m_dir, m_s1, m_s2;
  logic       m_rsel;

  always #4 clk = ~clk;

  gpio_port_ovr uut (
    .clk(clk), .rst(rst), .wdata(wdata), .data_we(data_we), .dir_we(dir_we),
    .rd_sel(rd_sel), .rdata(rdata), .per_sel(per_sel), .per_dout(per_dout),
    .per_oe(per_oe), .per_din(per_din), .lvl_mode(lvl_mode),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in), .pad_lvl(pad_lvl)
  );

  function automatic logic [7:0] f_oe(input logic [7:0] dir, sel, poe);
    return (sel & poe) | (~sel & ~dir);
  endfunction

  function automatic logic [7:0] f_out(input logic [7:0] dat, sel, pdo);
    return (sel & pdo) | (~sel & dat);
  endfunction

  function automatic logic [7:0] f_lvl(input logic m);
    return m ? 8'b0001_1000 : 8'b0000_0000;
  endfunction

  task automatic check(input string req, input logic [7:0] act, exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    wdata = 0; data_we = 0; dir_we = 0; rd_sel = 0;
    per_sel = 0; per_dout = 0; per_oe = 0; lvl_mode = 0; pad_in = 0;
  endtask

  // One clock: the model advances at the rising edge, checks follow it
  task automatic tick_and_check();
    @(posedge clk);
    if (data_we) m_data = wdata;
    if (dir_we)  m_dir  = wdata;
    m_s2 = m_s1; m_s1 = pad_in;
    m_rsel = rd_sel;
    #2;
    check("R2/R3 pad_out", pad_out, f_out(m_data, per_sel, per_dout));
    check("R2/R4 pad_oe", pad_oe, f_oe(m_dir, per_sel, per_oe));
    check("R6 per_din", per_din, m_s2);
    check("R5/R6/R10 rdata", rdata, m_rsel ? m_dir : m_s2);
    check("R7 pad_lvl", pad_lvl, f_lvl(lvl_mode));
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_data = 0; m_dir = 8'hff; m_s1 = 0; m_s2 = 0; m_rsel = 0;
    // R1 reset state
    rd_sel = 1;
    tick_and_check();
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 dir read", rdata, 8'hff);

    // R8 write latch while input, then release direction
    wdata = 8'ha5; data_we = 1;
    tick_and_check();
    data_we = 0;
    check("R8 still undriven", pad_oe, 8'h00);
    check("R9 dir untouched", rdata, 8'hff);
    wdata = 8'h0f; dir_we = 1;
    tick_and_check();
    dir_we = 0;
    check("R8 drive after clear", pad_oe, 8'hf0);
    check("R8 latched value", pad_out, 8'ha5);
    check("R9 data untouched", pad_out & pad_oe, 8'ha0);

    // R4 force input on an output pin, force output on an input pin
    per_sel = 8'h81; per_oe = 8'h01; per_dout = 8'h00;
    tick_and_check();
    check("R4 force", pad_oe, 8'h71);
    check("R5 dir read ignores takeover", rdata, 8'h0f);
    check("R3 peripheral value", pad_out, 8'h24);

    // R10 registered selector: live change not yet visible
    pad_in = 8'h3c;
    tick_and_check();
    tick_and_check();
    rd_sel = 0;
    #1;
    check("R10 old selector", rdata, 8'h0f);
    tick_and_check();
    check("R6 pins read", rdata, 8'h3c);
    lvl_mode = 1;
    #1;
    check("R7 mode flags", pad_lvl, 8'h18);

    // Random mix
    for (int it = 0; it < 400; it++) begin
      wdata    = 8'($urandom);
      data_we  = ($urandom % 3) == 0;
      dir_we   = ($urandom % 3) == 0;
      rd_sel   = 1'($urandom);
      per_sel  = 8'($urandom) & 8'($urandom);
      per_dout = 8'($urandom);
      per_oe   = 8'($urandom);
      lvl_mode = 1'($urandom);
      pad_in   = 8'($urandom);
      tick_and_check();
    end

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule